// File: doc/BRIEF.md
# Pulse-Width Modulator with Queued Duty Samples

This block produces one pulse-width modulated output from the core clock. A prescaler divides the clock into ticks. A period counter runs over a programmable number of ticks, and the output is active from each counter restart until the counter reaches the active duty sample. Duty samples are written through a register bus into a four-word queue. One is taken from the queue when the block starts, and another at each period boundary once the current sample has been used a programmable number of times. When the queue runs dry, the last sample stays in use.

Software sets up the period, prescaler, polarity and repeat count, preloads duty samples and then sets the enable bit. Afterwards it keeps the queue topped up while watching the fill level and the sticky event flags in the status register. The flags also drive a level interrupt. A self-clearing reset bit returns every register, counter and the queue to their idle state.

Top module: `pwm_sfifo`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x0C (duty sample) and 0x10 (period). Control reads back enable at bit 0, repeat at bits 2:1, prescaler at bits 15:4 and output mode at bits 19:18, with all other bits 0. Period reads back the 16-bit value that was written.
- R2: One output period lasts the period register value plus 2 ticks. A programmed 0xFFFF acts exactly like 0xFFFE.
- R3: A prescaler field value of p makes one tick every p+1 clock cycles.
- R4: With counter value c and active duty d, the output is (c < d) in output mode 0, the inverse of that in mode 1, and constant 0 in modes 2 and 3.
- R5: While the enable bit is 0, the output is 0 in every output mode.
- R6: The sample queue holds 4 words. Status bits 2:0 give the number of queued words (0 to 4), and status bit 3 reads 1 exactly while the queue is empty.
- R7: A sample write while 4 words are queued is dropped and sets status bit 6. Writing 1 to status bits 4, 5 or 6 clears that flag. The interrupt output is the OR of status bits 4 to 6.
- R8: A sample is taken from the queue on the control write that turns enable from 0 to 1, and at a period end when the repeat count is used up. If the queue is empty, the active sample is kept.
- R9: Repeat field values 0, 1, 2 and 3 use each sample for 1, 2, 4 and 8 periods.
- R10: Reading the sample register returns the active duty while enabled, and 0 while disabled.
- R11: Writing 1 to control bit 3 clears every register, the counters and the queue. Bit 3 then reads 1 for RST_CYCLES (default 4) cycles, and bus writes in that time are ignored.
- R12: Status bit 4 is set at each period end. Status bit 5 is set whenever the block is enabled and the counter equals the active duty.
- R13: A sample write that falls in the same cycle as a queue take both take effect, and the fill level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | OR of the sticky status flags |
| pwm_out | output | 1 | Modulated output |

## Verification
The case that needs the most care is a bus write to the sample register that lands on the same clock edge as the queue take at a period end. Both the push and the pop then change the fill count and the read and write pointers at once. The bench preloads two samples, enables the block with a four-tick period and counts cycles so that a third write hits the edge where the counter wraps. It then expects the fill level to stay at one and the sample register to show the second preloaded word. The bench also checks the output against a cycle model, and a bound property checks that the fill level holds whenever a push and a pop coincide.

// File: rtl/pwm_sfifo_pkg.sv
package pwm_sfifo_pkg;
  // register byte offsets
  localparam int unsigned OFS_CTRL   = 32'h00;
  localparam int unsigned OFS_STAT   = 32'h04;
  localparam int unsigned OFS_SAMPLE = 32'h0C;
  localparam int unsigned OFS_PERIOD = 32'h10;

  // control field positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_RPT    = 1;
  localparam int unsigned CB_SWR    = 3;
  localparam int unsigned CB_PRE    = 4;
  localparam int unsigned CB_OCFG   = 18;

  // status field positions
  localparam int unsigned SB_EMPTY  = 3;
  localparam int unsigned SB_ROV    = 4;
  localparam int unsigned SB_CMP    = 5;
  localparam int unsigned SB_WERR   = 6;

  typedef enum logic [1:0] {
    OUT_NORMAL = 2'd0,
    OUT_INVERT = 2'd1,
    OUT_OFF    = 2'd2,
    OUT_OFF2   = 2'd3
  } out_mode_e;
endpackage

// File: rtl/pwm_sfifo_queue.sv
module pwm_sfifo_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [FW-1:0] fill,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [FW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fill  = cnt_q;
  assign full  = (cnt_q == FW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = nxt(wp_q);
      if (pop)  rp_d = nxt(rp_q);
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= din;
  end
endmodule

// File: rtl/pwm_sfifo_timebase.sv
module pwm_sfifo_timebase #(
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 12
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           run,
  input  logic [PSW-1:0] div_m1,
  input  logic [CW-1:0]  last,
  output logic [CW-1:0]  cnt,
  output logic           wrap
);
  logic [PSW-1:0] pre_q, pre_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           tick;

  assign tick = run && (pre_q == div_m1);
  assign wrap = tick && (cnt_q >= last);
  assign cnt  = cnt_q;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (!run) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_sfifo.sv
module pwm_sfifo
  import pwm_sfifo_pkg::*;
#(
  parameter int unsigned AW         = 5,
  parameter int unsigned DW         = 16,
  parameter int unsigned PSW        = 12,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned FW        = $clog2(DEPTH + 1),
  localparam int unsigned RCW       = $clog2(RST_CYCLES + 1),
  localparam int unsigned REPW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          pwm_out
);
  localparam logic [DW-1:0] PER_MAX = {{(DW-1){1'b1}}, 1'b0};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // state
  logic             en_q, en_d;
  logic [1:0]       rpt_q, rpt_d;
  logic [PSW-1:0]   pre_q, pre_d;
  logic [1:0]       ocfg_q, ocfg_d;
  logic [DW-1:0]    per_q, per_d;
  logic [DW-1:0]    duty_q, duty_d;
  logic [REPW-1:0]  rep_q, rep_d;
  logic [RCW-1:0]   rcnt_q, rcnt_d;
  logic             rov_q, rov_d, cmp_q, cmp_d, werr_q, werr_d;

  // decode
  logic busy, wr_ctrl, wr_stat, wr_samp, wr_per;
  logic swr_start, start, rep_done, wrap;
  logic fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [FW-1:0]   fifo_fill;
  logic [DW-1:0]   fifo_dout, cnt, last;
  logic [REPW-1:0] rep_lim;

  assign busy      = (rcnt_q != '0);
  assign wr_ctrl   = bus_we && !busy && (bus_addr == AW'(OFS_CTRL));
  assign wr_stat   = bus_we && !busy && (bus_addr == AW'(OFS_STAT));
  assign wr_samp   = bus_we && !busy && (bus_addr == AW'(OFS_SAMPLE));
  assign wr_per    = bus_we && !busy && (bus_addr == AW'(OFS_PERIOD));
  assign swr_start = wr_ctrl && bus_wdata[CB_SWR];
  assign start     = wr_ctrl && !bus_wdata[CB_SWR] && bus_wdata[CB_EN] && !en_q;

  always_comb begin
    case (rpt_q)
      2'd0:    rep_lim = REPW'(0);
      2'd1:    rep_lim = REPW'(1);
      2'd2:    rep_lim = REPW'(3);
      default: rep_lim = REPW'(7);
    endcase
  end
  assign rep_done  = (rep_q == rep_lim);
  assign fifo_push = wr_samp && !fifo_full;
  assign fifo_pop  = !fifo_empty && !swr_start && (start || (wrap && rep_done));
  assign last      = ((per_q > PER_MAX) ? PER_MAX : per_q) + 1'b1;

  pwm_sfifo_queue #(.DEPTH(DEPTH), .W(DW)) u_queue (
    .clk(clk), .rst_ni(rst_ni), .flush(swr_start),
    .push(fifo_push), .pop(fifo_pop), .din(bus_wdata[DW-1:0]),
    .dout(fifo_dout), .fill(fifo_fill), .full(fifo_full), .empty(fifo_empty)
  );

  pwm_sfifo_timebase #(.CW(DW), .PSW(PSW)) u_tbase (
    .clk(clk), .rst_ni(rst_ni), .run(en_q), .div_m1(pre_q),
    .last(last), .cnt(cnt), .wrap(wrap)
  );

  // next state
  always_comb begin
    en_d   = en_q;   rpt_d  = rpt_q;  pre_d  = pre_q;  ocfg_d = ocfg_q;
    per_d  = per_q;  duty_d = duty_q; rep_d  = rep_q;  rcnt_d = rcnt_q;
    rov_d  = rov_q;  cmp_d  = cmp_q;  werr_d = werr_q;
    if (swr_start) begin
      en_d = 1'b0; rpt_d = '0; pre_d = '0; ocfg_d = '0; per_d = '0;
      duty_d = '0; rep_d = '0; rov_d = 1'b0; cmp_d = 1'b0; werr_d = 1'b0;
      rcnt_d = RCW'(RST_CYCLES);
    end else begin
      if (busy) rcnt_d = rcnt_q - 1'b1;
      if (wr_ctrl) begin
        en_d   = bus_wdata[CB_EN];
        rpt_d  = bus_wdata[CB_RPT +: 2];
        pre_d  = bus_wdata[CB_PRE +: PSW];
        ocfg_d = bus_wdata[CB_OCFG +: 2];
      end
      if (wr_per) per_d = bus_wdata[DW-1:0];
      if (start)     rep_d = '0;
      else if (wrap) rep_d = rep_done ? '0 : rep_q + 1'b1;
      if (fifo_pop) duty_d = fifo_dout;
      if (wr_stat) begin
        if (bus_wdata[SB_ROV])  rov_d  = 1'b0;
        if (bus_wdata[SB_CMP])  cmp_d  = 1'b0;
        if (bus_wdata[SB_WERR]) werr_d = 1'b0;
      end
      if (wrap)                      rov_d  = 1'b1;
      if (en_q && (cnt == duty_q))   cmp_d  = 1'b1;
      if (wr_samp && fifo_full)      werr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; rpt_q <= '0; pre_q <= '0; ocfg_q <= '0; per_q <= '0;
      duty_q <= '0; rep_q <= '0; rcnt_q <= '0;
      rov_q <= 1'b0; cmp_q <= 1'b0; werr_q <= 1'b0;
    end else begin
      en_q <= en_d; rpt_q <= rpt_d; pre_q <= pre_d; ocfg_q <= ocfg_d; per_q <= per_d;
      duty_q <= duty_d; rep_q <= rep_d; rcnt_q <= rcnt_d;
      rov_q <= rov_d; cmp_q <= cmp_d; werr_q <= werr_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_CTRL): begin
        bus_rdata[CB_EN]            = en_q;
        bus_rdata[CB_RPT +: 2]      = rpt_q;
        bus_rdata[CB_SWR]           = busy;
        bus_rdata[CB_PRE +: PSW]    = pre_q;
        bus_rdata[CB_OCFG +: 2]     = ocfg_q;
      end
      AW'(OFS_STAT): begin
        bus_rdata[FW-1:0]    = fifo_fill;
        bus_rdata[SB_EMPTY]  = fifo_empty;
        bus_rdata[SB_ROV]    = rov_q;
        bus_rdata[SB_CMP]    = cmp_q;
        bus_rdata[SB_WERR]   = werr_q;
      end
      AW'(OFS_SAMPLE): bus_rdata[DW-1:0] = en_q ? duty_q : '0;
      AW'(OFS_PERIOD): bus_rdata[DW-1:0] = per_q;
      default:         bus_rdata = '0;
    endcase
  end

  // output stage
  logic active;
  assign active = (cnt < duty_q);
  always_comb begin
    case (out_mode_e'(ocfg_q))
      OUT_NORMAL: pwm_out = en_q && active;
      OUT_INVERT: pwm_out = en_q && !active;
      default:    pwm_out = 1'b0;
    endcase
  end
  assign irq = rov_q || cmp_q || werr_q;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:20], bus_wdata[17:16]};
endmodule

// File: rtl/pwm_sfifo_chk.sv
module pwm_sfifo_chk
  import pwm_sfifo_pkg::*;
#(
  parameter int unsigned AW    = 5,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned FW    = 3
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          en,
  input logic          pwm_out,
  input logic [FW-1:0] fill,
  input logic          push,
  input logic          pop,
  input logic          werr,
  input logic          busy
);
  // R5
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |-> !pwm_out);

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fill <= FW'(DEPTH));

  // R7
  full_write_err_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && !busy && bus_addr == AW'(OFS_SAMPLE) && fill == FW'(DEPTH)) |=> werr);

  // R11
  swreset_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (fill == '0 && !en));

  // R13
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && pop) |=> $stable(fill));
endmodule

bind pwm_sfifo pwm_sfifo_chk #(.AW(AW), .DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .bus_we(bus_we), .bus_addr(bus_addr),
  .en(en_q), .pwm_out(pwm_out), .fill(fifo_fill), .push(fifo_push),
  .pop(fifo_pop), .werr(werr_q), .busy(busy)
);

// File: tb/pwm_sfifo_tb.sv
`timescale 1ns/1ps
module pwm_sfifo_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq, pwm_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_sfifo u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .pwm_out(pwm_out)
  );

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SAMP = 5'h0C, A_PER = 5'h10;

  typedef struct packed {
    logic [15:0] per;
    logic [11:0] pre;
    logic [1:0]  rpt;
    logic [1:0]  cfg;
    logic [2:0]  n;
    logic [15:0] s0, s1, s2, s3;
    logic [7:0]  win;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'd6, 12'd0, 2'd0, 2'd0, 3'd4, 16'd2, 16'd5, 16'd8,  16'd0, 8'd48},
    '{16'd3, 12'd2, 2'd1, 2'd1, 3'd2, 16'd1, 16'd4, 16'd0,  16'd0, 8'd90},
    '{16'd0, 12'd0, 2'd3, 2'd0, 3'd2, 16'd1, 16'd2, 16'd0,  16'd0, 8'd40},
    '{16'd4, 12'd1, 2'd0, 2'd2, 3'd1, 16'd3, 16'd0, 16'd0,  16'd0, 8'd30},
    '{16'd9, 12'd0, 2'd2, 2'd0, 3'd3, 16'd0, 16'd11, 16'd6, 16'd0, 8'd140}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic swreset();
    wr(A_CTRL, 32'h8);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic model_out(input vec_t v, input int t);
    int p, dv, reps, tk, c, k, idx, d;
    logic [15:0] s [4];
    s[0] = v.s0; s[1] = v.s1; s[2] = v.s2; s[3] = v.s3;
    p    = ((v.per > 16'hFFFE) ? 32'hFFFE : int'(v.per)) + 2;
    dv   = int'(v.pre) + 1;
    reps = 1 << v.rpt;
    tk   = t / dv;
    c    = tk % p;
    k    = tk / p;
    idx  = k / reps;
    if (idx > int'(v.n) - 1) idx = int'(v.n) - 1;
    d    = (v.n == 0) ? 0 : int'(s[idx]);
    case (v.cfg)
      2'd0:    return c < d;
      2'd1:    return !(c < d);
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd(A_CTRL, r); chk("R1 reset ctrl", r, 32'h0);
    rd(A_STAT, r); chk("R6 reset status empty", r, 32'h8);
    rd(A_PER, r);  chk("R1 reset period", r, 32'h0);
    rd(A_SAMP, r); chk("R10 reset sample", r, 32'h0);
    chk("R5 reset pwm_out", {31'b0, pwm_out}, 32'h0);
    chk("R7 reset irq", {31'b0, irq}, 32'h0);

    // table of output patterns
    for (int i = 0; i < 5; i++) begin
      int mism;
      swreset();
      wr(A_PER, {16'b0, VECS[i].per});
      if (VECS[i].n > 0) wr(A_SAMP, {16'b0, VECS[i].s0});
      if (VECS[i].n > 1) wr(A_SAMP, {16'b0, VECS[i].s1});
      if (VECS[i].n > 2) wr(A_SAMP, {16'b0, VECS[i].s2});
      if (VECS[i].n > 3) wr(A_SAMP, {16'b0, VECS[i].s3});
      wr(A_CTRL, {12'b0, VECS[i].cfg, 2'b0, VECS[i].pre, 1'b0, VECS[i].rpt, 1'b1});
      mism = 0;
      for (int t = 0; t < int'(VECS[i].win); t++) begin
        if (pwm_out !== model_out(VECS[i], t)) mism++;
        @(negedge clk);
      end
      // R2 R3 R4 R8 R9: waveform vs cycle model
      chk($sformatf("R4 R2 R3 R8 R9 vector %0d mismatches", i), mism, 0);
      if (i == 0) begin
        rd(A_STAT, r); chk("R12 rollover and compare flags", r & 32'h30, 32'h30);
        chk("R7 irq follows flags", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h70);
        rd(A_STAT, r); chk("R7 flags clear on write-one", r & 32'h70, 32'h0);
        chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
      end
    end

    // control and period read-back, disabled output with inversion
    swreset();
    wr(A_CTRL, 32'hF004AB54);
    rd(A_CTRL, r); chk("R1 ctrl fields read back", r, 32'h0004AB54);
    chk("R5 disabled inverted output low", {31'b0, pwm_out}, 32'h0);
    wr(A_PER, 32'hABCD1234);
    rd(A_PER, r);  chk("R1 period read back", r, 32'h1234);

    // queue fill and overflow
    swreset();
    wr(A_SAMP, 32'd3); wr(A_SAMP, 32'd4);
    rd(A_STAT, r); chk("R6 fill two", r, 32'h2);
    wr(A_SAMP, 32'd5); wr(A_SAMP, 32'd6); wr(A_SAMP, 32'd7);
    rd(A_STAT, r); chk("R7 full plus write error", r, 32'h44);
    chk("R7 irq on write error", {31'b0, irq}, 32'h1);
    rd(A_SAMP, r); chk("R10 sample reads 0 while disabled", r, 32'h0);
    wr(A_STAT, 32'h40);
    rd(A_STAT, r); chk("R7 write error cleared", r, 32'h4);
    wr(A_PER, 32'd2);
    wr(A_CTRL, 32'h1);
    rd(A_SAMP, r); chk("R10 R8 sample shows first queued word", r, 32'd3);
    rd(A_STAT, r); chk("R8 take on enable", r & 32'h7, 32'h3);

    // software reset
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, r); chk("R11 reset bit reads 1", r, 32'h8);
    rd(A_STAT, r); chk("R11 queue flushed", r, 32'h8);
    wr(A_PER, 32'h55);
    repeat (3) @(negedge clk);
    rd(A_CTRL, r); chk("R11 reset bit self-clears", r, 32'h0);
    rd(A_PER, r);  chk("R11 write during reset ignored", r, 32'h0);

    // push and pop on the same edge
    swreset();
    wr(A_PER, 32'd2);
    wr(A_SAMP, 32'd1); wr(A_SAMP, 32'd3);
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    wr(A_SAMP, 32'd7);
    rd(A_STAT, r); chk("R13 fill unchanged on push with pop", r & 32'h7, 32'h1);
    rd(A_SAMP, r); chk("R13 second word taken at wrap", r, 32'd3);

    // clamp of period 0xFFFF
    swreset();
    wr(A_PER, 32'hFFFF);
    wr(A_SAMP, 32'hFFFF);
    wr(A_CTRL, 32'h1);
    repeat (65534) @(negedge clk);
    chk("R2 high before end of period", {31'b0, pwm_out}, 32'h1);
    @(negedge clk);
    chk("R2 single low cycle at clamp", {31'b0, pwm_out}, 32'h0);
    @(negedge clk);
    chk("R2 period restarts after 65536", {31'b0, pwm_out}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule